// File: doc/BRIEF.md
# Parallel Lane Sample Rearranger

This block sits between a parallel sample source and a bank of per-lane interpolators in a wide timing-recovery datapath. Each clock may bring one word of `LANES` consecutive 8-bit samples, with separate I and Q paths that are handled the same way. The block keeps a read pointer into this sample stream. Each output word starts at that pointer, and the pointer normally moves forward by one word per output. When the timing loop finds that drift has built up, it can ask for one sample to be skipped or for one sample to be presented twice. This keeps a timing-frequency offset from pushing the sampling instant out of range.

For every lane the block delivers a window of four consecutive stream samples. A lane's window starts at its own position in the re-packed word. The windows of the last lanes run past the end of the current word into the samples that follow it. Only lane 0's start position comes from the stored offset. Every other lane adds its lane number to that base, so the selection logic needs no separate decode per lane. The 2-bit step control is driven by the most significant bits of the last lane's oscillator control word.

Top module: `lane_rearranger`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low and stays low until enough samples have arrived.
- R2: When `out_valid` is high, tap j of lane k on `out_i_win` (bits `(k*4+j)*8 +: 8`) equals I stream sample p+k+j, where p is the start position of the word. Input sample s of the n-th accepted word is stream sample n*LANES+s and sits at bits `s*8 +: 8`.
- R3: `out_q_win` follows the Q stream with the same positions and timing as R2.
- R4: Step code 2'b00 starts the next output word at p+LANES.
- R5: Step code 2'b01 (skip) starts the next output word at p+LANES+1, so one stream sample appears in no output word.
- R6: Step code 2'b10 (repeat) starts the next output word at p+LANES-1, so the last sample of a word also appears as the first sample of the next word.
- R7: Step code 2'b11 behaves exactly like 2'b00.
- R8: A word is produced only when every sample from p to p+LANES+2 has arrived. Once input stops, words keep being produced until fewer than LANES+3 unconsumed samples remain.
- R9: The step code is sampled on the same clock edge as the output word it follows. That word appears on the outputs one cycle later, and the next word starts at the position the code selected. The first word starts at stream sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An input word is present this cycle |
| in_i | input | LANES*8 | I samples, sample s at bits s*8 |
| in_q | input | LANES*8 | Q samples, same layout |
| ctrl | input | 2 | Step code: 00 pass, 01 skip, 10 repeat, 11 pass |
| out_valid | output | 1 | Output windows hold a new word |
| out_i_win | output | LANES*32 | I windows, lane k tap j at bits (k*4+j)*8 |
| out_q_win | output | LANES*32 | Q windows, same layout |

## Verification
The bench streams a counting pattern on I and a different arithmetic sequence on Q. It predicts every window from a pointer model and visits each start offset under every step code. The pointer model catches four kinds of fault: a skip or repeat applied one word late or in the wrong direction, an off-by-one lane adder, and code 11 treated as a skip or a repeat. Each of these shifts every later window by one sample. The bench also holds back the second word to check that no word is issued before the borrowed samples are present; a design that fired too early would latch stale samples into the last lanes' windows. Finally, it drains the stream to check that a design does not stall while enough samples remain.

// File: rtl/rearr_pkg.sv
package rearr_pkg;
    // Width of one I or Q sample
    localparam int SAMPLE_W = 8;
    // Samples each interpolator window spans
    localparam int TAPS = 4;

    // Step code supplied by the timing loop
    typedef enum logic [1:0] {
        STEP_PASS = 2'b00,
        STEP_SKIP = 2'b01,
        STEP_RPT  = 2'b10,
        STEP_ALT  = 2'b11
    } step_e;
endpackage

// File: rtl/rearr_store.sv
// Word store: holds incoming sample words in a small ring and exposes the
// three oldest words side by side (oldest at the low end).
// Assumes DEPTH is a power of two of at least 4, and that the source never
// presents a word while all DEPTH slots are occupied.
module rearr_store #(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    localparam int WW = LANES * rearr_pkg::SAMPLE_W,
    localparam int DW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [WW-1:0]   in_i,
    input  logic [WW-1:0]   in_q,
    input  logic [1:0]      pop_n,
    output logic [CW-1:0]   count,
    output logic [3*WW-1:0] view_i,
    output logic [3*WW-1:0] view_q
);
    logic [WW-1:0] mem_i [DEPTH];
    logic [WW-1:0] mem_q [DEPTH];
    logic [DW-1:0] wr_ptr;
    logic [DW-1:0] rd_ptr;
    logic          wr_ok;

    assign wr_ok = push && (count != CW'(DEPTH));

    // Ring pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + DW'(wr_ok);
            rd_ptr <= rd_ptr + DW'(pop_n);
            count  <= count + CW'(wr_ok) - CW'(pop_n);
        end
    end

    // Sample payload, no reset needed
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem_i[wr_ptr] <= in_i;
            mem_q[wr_ptr] <= in_q;
        end
    end

    // Expose the three oldest words
    for (genvar w = 0; w < 3; w++) begin : g_view
        logic [DW-1:0] slot;
        assign slot = rd_ptr + DW'(w);
        assign view_i[w*WW +: WW] = mem_i[slot];
        assign view_q[w*WW +: WW] = mem_q[slot];
    end

    // R8: the source must not write into a full store
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count != CW'(DEPTH)));

    // R8: the pointer logic never retires more words than are held
    p_pop_le_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count);
endmodule

// File: rtl/rearr_steer.sv
// Pointer steering: keeps the offset of the next output word inside the
// oldest stored word. Decides when a word can be formed and how many
// stored words that retires, applying the skip/repeat step code.
// Assumes LANES is a power of two of at least 4.
module rearr_steer #(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    localparam int LW = $clog2(LANES),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = CW + LW + 1,
    localparam int SW = LW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic [1:0]    ctrl,
    output logic          fire,
    output logic [1:0]    pop_n,
    output logic [LW-1:0] off
);
    import rearr_pkg::*;

    logic [SW-1:0] step;
    logic [SW-1:0] nxt;

    // A word needs LANES+3 samples from the offset onward
    assign fire = (AW'(count) * AW'(LANES)) >= (AW'(off) + AW'(LANES + 3));

    // Step size chosen by the code; 11 falls back to a plain pass
    always_comb begin
        case (step_e'(ctrl))
            STEP_SKIP: step = SW'(LANES + 1);
            STEP_RPT:  step = SW'(LANES - 1);
            default:   step = SW'(LANES);
        endcase
    end

    assign nxt   = SW'(off) + step;
    assign pop_n = fire ? nxt[SW-1:LW] : 2'd0;

    // Offset register advances only when a word is formed
    always_ff @(posedge clk) begin
        if (!rst_n) off <= '0;
        else if (fire) off <= nxt[LW-1:0];
    end

    // R1: an empty store never yields a word
    p_empty_no_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !fire);
endmodule

// File: rtl/rearr_pick.sv
// Window picker: lane 0 reads from the stored offset; each other lane adds
// its lane number to that base, and each tap adds its tap number. Produces
// TAPS consecutive samples per lane from three side-by-side words.
// Assumes the view holds every sample up to offset+LANES+2.
module rearr_pick #(
    parameter int LANES = 8,
    localparam int LW = $clog2(LANES),
    localparam int SW = LW + 2,
    localparam int SMP = rearr_pkg::SAMPLE_W,
    localparam int TP = rearr_pkg::TAPS
) (
    input  logic [3*LANES*SMP-1:0]  view,
    input  logic [LW-1:0]           off,
    output logic [LANES*TP*SMP-1:0] win
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SW-1:0] base;
        // Lane base index: shared offset plus lane number
        assign base = SW'(off) + SW'(k);
        for (genvar j = 0; j < TP; j++) begin : g_tap
            logic [SW-1:0] idx;
            assign idx = base + SW'(j);
            assign win[(k*TP+j)*SMP +: SMP] = view[int'(idx)*SMP +: SMP];
        end
    end
endmodule

// File: rtl/lane_rearranger.sv
// Top: parallel sample rearranger. Stores incoming words, steers a read
// pointer that can skip or repeat one sample per word, and registers
// per-lane four-sample windows for I and Q.
// Assumes LANES is a power of two of at least 4 and DEPTH a power of two
// of at least 4; the source must not overrun the store.
module lane_rearranger #(
    parameter int LANES = 8,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [LANES*8-1:0]   in_i,
    input  logic [LANES*8-1:0]   in_q,
    input  logic [1:0]           ctrl,
    output logic                 out_valid,
    output logic [LANES*32-1:0]  out_i_win,
    output logic [LANES*32-1:0]  out_q_win
);
    import rearr_pkg::*;

    localparam int LW = $clog2(LANES);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int WW = LANES * SAMPLE_W;
    localparam int OW = LANES * TAPS * SAMPLE_W;

    logic [CW-1:0]   count;
    logic [1:0]      pop_n;
    logic            fire;
    logic [LW-1:0]   off;
    logic [3*WW-1:0] view_i;
    logic [3*WW-1:0] view_q;
    logic [OW-1:0]   win_i;
    logic [OW-1:0]   win_q;

    rearr_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .in_i(in_i), .in_q(in_q),
        .pop_n(pop_n), .count(count), .view_i(view_i), .view_q(view_q)
    );

    rearr_steer #(.LANES(LANES), .DEPTH(DEPTH)) u_steer (
        .clk(clk), .rst_n(rst_n), .count(count), .ctrl(ctrl),
        .fire(fire), .pop_n(pop_n), .off(off)
    );

    rearr_pick #(.LANES(LANES)) u_pick_i (.view(view_i), .off(off), .win(win_i));
    rearr_pick #(.LANES(LANES)) u_pick_q (.view(view_q), .off(off), .win(win_q));

    // Output register: capture windows of the word formed this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i_win <= '0;
            out_q_win <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_i_win <= win_i;
                out_q_win <= win_q;
            end
        end
    end

    // R9: a formed word shows on the outputs one cycle later
    p_fire_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);

    // R6: after a repeat, the new first sample equals the previous last one
    p_repeat_joins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && ($past(ctrl, 2) == 2'b10))
        |-> (out_i_win[0 +: 8] == $past(out_i_win[(LANES-1)*32 +: 8])));
endmodule

// File: tb/sim_lane_rearranger.sv
module sim_lane_rearranger;
    localparam int CLK_PERIOD = 10;
    localparam int M = 4;
    localparam int D = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [M*8-1:0]  in_i = '0;
    logic [M*8-1:0]  in_q = '0;
    logic [1:0]      ctrl = 2'b00;
    logic            out_valid;
    logic [M*32-1:0] out_i_win;
    logic [M*32-1:0] out_q_win;

    int checks = 0;
    int fails = 0;
    int p = 0;          // expected start of the next output word
    int n_in = 0;       // words driven so far
    int idle_hits = 0;
    logic [15:0] lfsr = 16'hACE1;
    string tag = "R2/R3 first word R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_rearranger #(.LANES(M), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i),
        .in_q(in_q), .ctrl(ctrl), .out_valid(out_valid),
        .out_i_win(out_i_win), .out_q_win(out_q_win)
    );

    function automatic logic [7:0] i_of(input int n);
        return 8'(n);
    endfunction

    function automatic logic [7:0] q_of(input int n);
        return 8'(n * 5 + 7);
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // R2, R3: compare every lane/tap against stream positions p+k+j
    task automatic check_word();
        bit bad = 0;
        for (int k = 0; k < M; k++) begin
            for (int j = 0; j < 4; j++) begin
                logic [7:0] ai = out_i_win[(k*4+j)*8 +: 8];
                logic [7:0] aq = out_q_win[(k*4+j)*8 +: 8];
                if (!bad && (ai != i_of(p+k+j) || aq != q_of(p+k+j))) begin
                    $display("FAIL %s pos %0d lane %0d tap %0d: I=%0h exp %0h Q=%0h exp %0h",
                             tag, p, k, j, ai, i_of(p+k+j), aq, q_of(p+k+j));
                    bad = 1;
                end
            end
        end
        checks++;
        if (bad) fails++;
    endtask

    // One cycle: check the output, advance the model by the code that was
    // sampled with that word (R9), then drive the next inputs
    task automatic step(input logic want_v, input logic [1:0] c);
        logic v;
        @(negedge clk);
        if (out_valid) begin
            check_word();
            case (ctrl)
                2'b01: begin p += M + 1; tag = "R2/R3 after R5 skip"; end
                2'b10: begin p += M - 1; tag = "R2/R3 after R6 repeat"; end
                2'b11: begin p += M;     tag = "R2/R3 after R7 code"; end
                default: begin p += M;   tag = "R2/R3 after R4 pass"; end
            endcase
        end
        // keep the store from overrunning: backlog of at most two words
        v = want_v && ((n_in * M - p) <= 2 * M);
        in_valid = v;
        ctrl = c;
        if (v) begin
            for (int s = 0; s < M; s++) begin
                in_i[s*8 +: 8] = i_of(n_in * M + s);
                in_q[s*8 +: 8] = q_of(n_in * M + s);
            end
            n_in++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 out_valid after reset: got %b exp 0", out_valid);
        end

        // R8: one word is not enough to form a window set
        step(1'b1, 2'b00);
        for (int c = 0; c < 6; c++) begin
            step(1'b0, 2'b00);
            if (out_valid) idle_hits++;
        end
        checks++;
        if (idle_hits != 0) begin
            fails++;
            $display("FAIL R8 early word with one input word: got %0d exp 0", idle_hits);
        end

        // R4: plain passes at full input rate
        for (int c = 0; c < 60; c++) step(1'b1, 2'b00);
        // R6: repeats, every start offset visited
        for (int c = 0; c < 60; c++) step(c[0], 2'b10);
        // R5: skips, starving the output at times
        for (int c = 0; c < 60; c++) step(1'b1, 2'b01);
        // R7: code 11 must act as a pass
        for (int c = 0; c < 40; c++) step(1'b1, 2'b11);
        // Mixed codes and gappy input
        for (int c = 0; c < 1500; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[3:2]);
        end
        // Drain
        for (int c = 0; c < 20; c++) step(1'b0, 2'b00);

        // R8: drained down to fewer than M+3 samples and idle
        checks++;
        if ((n_in * M - p) >= M + 3 || out_valid) begin
            fails++;
            $display("FAIL R8 drain: remaining %0d exp < %0d, out_valid %b exp 0",
                     n_in * M - p, M + 3, out_valid);
        end
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end, got timeout exp completion");
        report();
        $finish;
    end
endmodule